// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

The walker turns a 64-bit virtual address into a real address. It does this by reading translation-table entries from memory one level at a time. There are up to five levels: three region levels (first, second and third), then a segment level, then a page level. With each request the caller supplies an address-space selector and a table origin. The selector names the highest table the space has, and the walk begins at that table. Before any memory read, the walker checks that the virtual address does not use index bits above that starting level.

A request is accepted on a valid/ready handshake, and only one translation is in flight at a time. Table entries are fetched through a read port that holds its request until the memory answers. Memory may take any number of cycles to answer. Each entry holds a valid flag in bit 0 and the origin of the next table. The page-level entry holds a frame origin instead. A translation ends in one of two ways: a real address with exception code 0, or an exception code that names the cause. The result is presented as a one-cycle pulse.

Top module: `xlate_walker`

## Requirements
- R1: The virtual address is split into fields, counting bit 63 as the most significant bit. The region-first index is va[63:53], the region-second index is va[52:42] and the region-third index is va[41:31]. The segment index is va[30:20], the page index is va[19:12] and the byte offset is va[11:0].
- R2: The selector picks the starting table: 0 = segment, 1 = region third, 2 = region second, 3 = region first. The first entry read is at (origin with bits 2:0 cleared) + index of the starting level × 8.
- R3: With selector 0, any set bit in va[63:31] ends the request with exception code 1, and no memory read is made.
- R4: With selector 1, any set bit in va[63:42] gives exception code 1. With selector 2, any set bit in va[63:53] gives exception code 1. Selector 3 never raises code 1. In every such case no memory read is made.
- R5: After a valid entry above the page level, the walker reads one level lower. The read address is (entry with bits 2:0 cleared) + that level's index × 8. The walk visits every level from the start level down to the page level, in order.
- R6: An entry with bit 0 clear ends the walk at once, with no further reads. The exception code depends on the level: 2 region first, 3 region second, 4 region third, 5 segment, 6 page.
- R7: A valid page-level entry ends the walk with exception code 0. The real address is entry[63:12] joined with va[11:0].
- R8: req_ready is high only when the walker is idle. It is low from the cycle after acceptance through the cycle in which resp_valid is high. resp_valid is a one-cycle pulse, and req_ready is high again in the next cycle.
- R9: mem_rd_en stays high, with mem_rd_addr unchanged, until mem_rd_valid is seen.
- R10: After reset, req_ready is 1, and resp_valid and mem_rd_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle if valid |
| req_va | input | 64 | Virtual address to translate |
| req_space_sel | input | 2 | Starting table selector |
| req_origin | input | 64 | Origin of the starting table |
| mem_rd_en | output | 1 | Table-entry read request |
| mem_rd_addr | output | 64 | Byte address of the entry |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 64 | Table entry |
| resp_valid | output | 1 | Result pulse |
| resp_exc | output | 4 | Exception code, 0 on success |
| resp_ra | output | 64 | Real address, 0 on exception |

## Verification
The walk level is state held inside the block. If it is wrong, a wrong index field is added to the origin, and mem_rd_addr shows the error on the very next read. A wrong level also shows up as a missing or extra read before the response, or as the wrong invalid-code level. A latched address or origin that is bad also shows up at the next read address. A bad result, or a bad index split, shows up at resp_valid in the same transaction. The sweep varies the starting level, the index values, the in-range and out-of-range upper bits, the invalid level and the memory latency. Each fault therefore reaches the ports within one request.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  // Walk depth: 0 is the top region table, 4 the page table.
  typedef enum logic [2:0] {
    LV_R1  = 3'd0,
    LV_R2  = 3'd1,
    LV_R3  = 3'd2,
    LV_SEG = 3'd3,
    LV_PG  = 3'd4
  } lvl_e;

  typedef enum logic [3:0] {
    EX_NONE   = 4'd0,
    EX_SIZE   = 4'd1,
    EX_R1_INV = 4'd2,
    EX_R2_INV = 4'd3,
    EX_R3_INV = 4'd4,
    EX_SG_INV = 4'd5,
    EX_PG_INV = 4'd6
  } exc_e;

  // Invalid-entry code for a level: codes follow walk depth.
  function automatic exc_e inv_code(lvl_e l);
    return exc_e'({1'b0, l} + 4'd2);
  endfunction

  // Start depth from the space selector (0 = segment ... 3 = top region).
  function automatic lvl_e start_of(logic [1:0] sel);
    return lvl_e'(3'd3 - {1'b0, sel});
  endfunction

endpackage

// File: rtl/xlate_va_fields.sv
module xlate_va_fields
  import xlate_pkg::*;
#(
  parameter int RIX_W = 11,
  parameter int SX_W  = 11,
  parameter int PX_W  = 8,
  parameter int BX_W  = 12,
  parameter int IW    = 11
) (
  input  logic [3*RIX_W+SX_W+PX_W+BX_W-1:BX_W] va_hi,
  input  logic [1:0]                           space_sel,
  output logic [4:0][IW-1:0]                   idx_arr,
  output lvl_e                                 start_lvl,
  output logic                                 size_fault
);
  localparam int VA_W = 3*RIX_W + SX_W + PX_W + BX_W;

  logic [2:0] reg_nz;

  // One slice per region level, top table first.
  for (genvar g = 0; g < 3; g++) begin : g_region
    localparam int HI = VA_W - 1 - g*RIX_W;
    assign idx_arr[g] = IW'(va_hi[HI -: RIX_W]);
    assign reg_nz[g]  = |va_hi[HI -: RIX_W];
  end

  assign idx_arr[3] = IW'(va_hi[BX_W+PX_W+SX_W-1 -: SX_W]);
  assign idx_arr[4] = IW'(va_hi[BX_W+PX_W-1 -: PX_W]);

  assign start_lvl = start_of(space_sel);

  // Region indices above the start table must all be zero.
  always_comb begin
    case (space_sel)
      2'd0:    size_fault = |reg_nz;
      2'd1:    size_fault = reg_nz[0] | reg_nz[1];
      2'd2:    size_fault = reg_nz[0];
      default: size_fault = 1'b0;
    endcase
  end

endmodule

// File: rtl/xlate_entry_addr.sv
module xlate_entry_addr #(
  parameter int ADDR_W = 64,
  parameter int IW     = 11,
  parameter int ESHIFT = 3
) (
  input  logic [ADDR_W-1:0] tbl_origin,
  input  logic [IW-1:0]     tbl_index,
  output logic [ADDR_W-1:0] entry_addr
);
  function automatic logic [ADDR_W-1:0] calc(logic [ADDR_W-1:0] org,
                                             logic [IW-1:0]     idx);
    return org + (ADDR_W'(idx) << ESHIFT);
  endfunction

  assign entry_addr = calc(tbl_origin, tbl_index);

endmodule

// File: rtl/xlate_walk_ctrl.sv
module xlate_walk_ctrl
  import xlate_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int VA_W   = 64,
  parameter int BX_W   = 12,
  parameter int ESHIFT = 3,
  parameter int VLD    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_space_sel,
  input  logic [ADDR_W-1:0] req_origin,
  output logic [VA_W-1:0]   va_q,
  output logic [1:0]        sel_q,
  input  logic              size_fault,
  input  lvl_e              start_lvl,
  output lvl_e              cur_lvl,
  output logic [ADDR_W-1:0] cur_org,
  output logic              mem_rd_en,
  input  logic              mem_rd_valid,
  input  logic [ADDR_W-1:0] mem_rd_data,
  output logic              resp_valid,
  output logic [3:0]        resp_exc,
  output logic [ADDR_W-1:0] resp_ra
);
  localparam logic [ADDR_W-1:0] ORG_MASK = {{(ADDR_W-ESHIFT){1'b1}}, {ESHIFT{1'b0}}};

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_FETCH, ST_DONE} st_e;
  st_e state;

  exc_e              exc_q;
  logic [ADDR_W-1:0] ra_q;

  // Named internal events.
  logic accept, fetch_done, entry_ok, at_page;
  assign accept     = (state == ST_IDLE) && req_valid;
  assign fetch_done = (state == ST_FETCH) && mem_rd_valid;
  assign entry_ok   = mem_rd_data[VLD];
  assign at_page    = (cur_lvl == LV_PG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      va_q    <= '0;
      sel_q   <= '0;
      cur_lvl <= LV_R1;
      cur_org <= '0;
      exc_q   <= EX_NONE;
      ra_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          va_q    <= req_va;
          sel_q   <= req_space_sel;
          cur_org <= req_origin & ORG_MASK;
          state   <= ST_CHECK;
        end
        ST_CHECK: begin
          if (size_fault) begin
            exc_q <= EX_SIZE;
            ra_q  <= '0;
            state <= ST_DONE;
          end else begin
            cur_lvl <= start_lvl;
            state   <= ST_FETCH;
          end
        end
        ST_FETCH: if (fetch_done) begin
          if (!entry_ok) begin
            exc_q <= inv_code(cur_lvl);
            ra_q  <= '0;
            state <= ST_DONE;
          end else if (at_page) begin
            exc_q <= EX_NONE;
            ra_q  <= {mem_rd_data[ADDR_W-1:BX_W], va_q[BX_W-1:0]};
            state <= ST_DONE;
          end else begin
            cur_lvl <= lvl_e'(cur_lvl + 3'd1);
            cur_org <= mem_rd_data & ORG_MASK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign mem_rd_en  = (state == ST_FETCH);
  assign resp_valid = (state == ST_DONE);
  assign resp_exc   = exc_q;
  assign resp_ra    = ra_q;

  a_r8_ready_low_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);
  a_r8_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && req_ready);
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && !mem_rd_valid |=> mem_rd_en);
  a_r3_size_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHECK) && size_fault |=> resp_valid && resp_exc == EX_SIZE && !mem_rd_en);
  a_r5_descend: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done && entry_ok && !at_page |=> mem_rd_en && cur_lvl == lvl_e'($past(cur_lvl) + 3'd1));
  a_r6_invalid_ends: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done && !entry_ok |=> resp_valid && resp_exc >= 4'd2 && resp_exc <= 4'd6);
  a_r7_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_exc == 4'd0 |-> resp_ra[BX_W-1:0] == va_q[BX_W-1:0]);

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int RIX_W  = 11,
  parameter int SX_W   = 11,
  parameter int PX_W   = 8,
  parameter int BX_W   = 12,
  parameter int ESHIFT = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [3*RIX_W+SX_W+PX_W+BX_W-1:0]    req_va,
  input  logic [1:0]                           req_space_sel,
  input  logic [ADDR_W-1:0]                    req_origin,
  output logic                                 mem_rd_en,
  output logic [ADDR_W-1:0]                    mem_rd_addr,
  input  logic                                 mem_rd_valid,
  input  logic [ADDR_W-1:0]                    mem_rd_data,
  output logic                                 resp_valid,
  output logic [3:0]                           resp_exc,
  output logic [ADDR_W-1:0]                    resp_ra
);
  localparam int VA_W = 3*RIX_W + SX_W + PX_W + BX_W;
  localparam int W1   = (RIX_W > SX_W) ? RIX_W : SX_W;
  localparam int IW   = (W1 > PX_W) ? W1 : PX_W;

  logic [VA_W-1:0]   va_q;
  logic [1:0]        sel_q;
  logic [4:0][IW-1:0] idx_arr;
  lvl_e              start_lvl;
  lvl_e              cur_lvl;
  logic              size_fault;
  logic [ADDR_W-1:0] cur_org;
  logic [IW-1:0]     cur_idx;

  xlate_va_fields #(
    .RIX_W(RIX_W), .SX_W(SX_W), .PX_W(PX_W), .BX_W(BX_W), .IW(IW)
  ) u_fields (
    .va_hi      (va_q[VA_W-1:BX_W]),
    .space_sel  (sel_q),
    .idx_arr    (idx_arr),
    .start_lvl  (start_lvl),
    .size_fault (size_fault)
  );

  assign cur_idx = idx_arr[cur_lvl];

  xlate_entry_addr #(
    .ADDR_W(ADDR_W), .IW(IW), .ESHIFT(ESHIFT)
  ) u_eaddr (
    .tbl_origin (cur_org),
    .tbl_index  (cur_idx),
    .entry_addr (mem_rd_addr)
  );

  xlate_walk_ctrl #(
    .ADDR_W(ADDR_W), .VA_W(VA_W), .BX_W(BX_W), .ESHIFT(ESHIFT), .VLD(0)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .req_space_sel (req_space_sel),
    .req_origin    (req_origin),
    .va_q          (va_q),
    .sel_q         (sel_q),
    .size_fault    (size_fault),
    .start_lvl     (start_lvl),
    .cur_lvl       (cur_lvl),
    .cur_org       (cur_org),
    .mem_rd_en     (mem_rd_en),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_data   (mem_rd_data),
    .resp_valid    (resp_valid),
    .resp_exc      (resp_exc),
    .resp_ra       (resp_ra)
  );

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && !mem_rd_valid |=> $stable(mem_rd_addr));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_en && !resp_valid);

endmodule

// File: tb/xlate_walker_bench.sv
module xlate_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [1:0]  req_space_sel = '0;
  logic [63:0] req_origin = '0;
  logic        mem_rd_en;
  logic [63:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic        resp_valid;
  logic [3:0]  resp_exc;
  logic [63:0] resp_ra;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_walker u_xlate_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_space_sel(req_space_sel), .req_origin(req_origin),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .resp_valid(resp_valid), .resp_exc(resp_exc),
    .resp_ra(resp_ra)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Table contents: a fixed hash of the entry address, valid bit set.
  function automatic logic [63:0] mdata(input logic [63:0] a);
    logic [63:0] h;
    h = (a * 64'h9E37_79B9_7F4A_7C15) ^ 64'hC3A5_0F0F_1234_5670;
    return h | 64'd1;
  endfunction

  // Index of walk depth s (0 top region ... 4 page), bit 63 = MSB.
  function automatic logic [63:0] fld(input logic [63:0] va, input int s);
    case (s)
      0: return (va >> 53) & 64'h7FF;
      1: return (va >> 42) & 64'h7FF;
      2: return (va >> 31) & 64'h7FF;
      3: return (va >> 20) & 64'h7FF;
      default: return (va >> 12) & 64'hFF;
    endcase
  endfunction

  task automatic run(input logic [63:0] va, input logic [1:0] sel,
                     input logic [63:0] org, input int poison);
    logic [63:0] ex_addr [5];
    logic [63:0] o, d, ex_ra;
    logic [3:0]  ex_exc;
    int nexp, st, rd_cnt, guard, lat;
    bit oor, fresh, done;
    nexp = 0; ex_ra = '0; ex_exc = 4'd0;
    for (int i = 0; i < 5; i++) ex_addr[i] = '0;
    st  = 3 - int'(sel);
    oor = (sel != 2'd3) && ((va >> (31 + 11*int'(sel))) != 64'd0);
    if (oor) ex_exc = 4'd1;
    else begin
      o = org & ~64'h7;
      for (int s = st; s < 5; s++) begin
        ex_addr[nexp] = o + (fld(va, s) << 3);
        d = mdata(ex_addr[nexp]);
        nexp++;
        if (s == poison) begin ex_exc = 4'(2 + s); break; end
        if (s == 4) ex_ra = {d[63:12], va[11:0]};
        else o = d & ~64'h7;
      end
    end

    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready while idle", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_va = va; req_space_sel = sel; req_origin = org;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8 ready low after accept", {63'd0, req_ready}, 64'd0);
    rd_cnt = 0; guard = 0; fresh = 1'b1; done = 1'b0;
    while (!done && guard < 100) begin
      if (!fresh) @(negedge clk);
      fresh = 1'b0;
      guard++;
      if (resp_valid) begin
        done = 1'b1;
        if (ex_exc == 4'd1)
          chk(resp_exc == 4'd1, sel == 2'd0 ? "R3 size exception" : "R4 size exception",
              64'(resp_exc), 64'(ex_exc));
        else if (ex_exc != 4'd0)
          chk(resp_exc == ex_exc, "R6 invalid entry code", 64'(resp_exc), 64'(ex_exc));
        else begin
          chk(resp_exc == 4'd0, "R7 success code", 64'(resp_exc), 64'd0);
          chk(resp_ra == ex_ra, "R7 real address", resp_ra, ex_ra);
        end
        chk(rd_cnt == nexp, "R5 read count", 64'(rd_cnt), 64'(nexp));
        chk(req_ready == 1'b0, "R8 ready low with result", {63'd0, req_ready}, 64'd0);
      end else if (mem_rd_en) begin
        if (rd_cnt < nexp)
          chk(mem_rd_addr == ex_addr[rd_cnt],
              rd_cnt == 0 ? "R2 R1 first entry address" : "R5 R1 next entry address",
              mem_rd_addr, ex_addr[rd_cnt]);
        else
          chk(1'b0, "R6 R3 unexpected read", 64'(rd_cnt), 64'(nexp));
        lat = (rd_cnt + int'(va[3:0])) % 3;
        for (int k = 0; k < lat; k++) @(negedge clk);
        if (rd_cnt < nexp)
          chk(mem_rd_en && mem_rd_addr == ex_addr[rd_cnt], "R9 request held",
              mem_rd_addr, ex_addr[rd_cnt]);
        mem_rd_data = mdata(mem_rd_addr);
        if (st + rd_cnt == poison) mem_rd_data[0] = 1'b0;
        mem_rd_valid = 1'b1;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        rd_cnt++;
        fresh = 1'b1;
      end
    end
    if (!done) chk(1'b0, "R8 no result", 64'd0, 64'd1);
    @(negedge clk);
    chk(req_ready == 1'b1 && resp_valid == 1'b0, "R8 ready returns, pulse ends",
        {62'd0, req_ready, resp_valid}, 64'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] base, lo, org;
    int lim;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1 && resp_valid == 1'b0 && mem_rd_en == 1'b0,
        "R10 reset state", {61'd0, req_ready, resp_valid, mem_rd_en}, 64'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_rd_en == 1'b0, "R10 idle after reset",
        {62'd0, req_ready, mem_rd_en}, 64'd2);

    for (int sel = 0; sel < 4; sel++) begin
      lim = 31 + 11*sel;
      for (int p = 0; p < 4; p++) begin
        base = (64'hDEAD_BEEF_0BAD_F00D * 64'(p + 3)) ^ (64'h1 << (p*7));
        lo   = (sel == 3) ? base : (base & ((64'd1 << lim) - 64'd1));
        org  = 64'h0000_4000_0000_0000 + 64'(p*8192 + sel*5);
        // in-range walks: no invalid entry, then invalid at each level walked
        run(lo, 2'(sel), org, -1);
        for (int pz = 3 - sel; pz < 5; pz++) run(lo, 2'(sel), org, pz);
        // out-of-range upper bits just above the start level, and the top bit
        if (sel != 3) begin
          run(lo | (64'd1 << lim), 2'(sel), org, -1);
          run(lo | (64'd1 << 63), 2'(sel), org, -1);
        end
      end
    end
    // Boundary patterns: all-zero and all-one addresses.
    run(64'd0, 2'd0, 64'h0000_0000_0001_0007, -1);
    run(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 64'h0000_0000_0002_0000, -1);
    run(64'h0000_0000_7FFF_FFFF, 2'd0, 64'h0, 4);
    run(64'h0000_0000_8000_0000, 2'd0, 64'h0, -1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule